// File: doc/BRIEF.md
# Software Interrupt Request Register

This block is a 16-bit register on a simple register bus. Software uses it to raise interrupt requests at seven priority levels. The upper byte holds one request flag per level: bit 8+n belongs to level n. Bit 8 is level 0. It can be written and read back, but it never causes a request. The lower byte is computed and cannot be written. It reports the highest pending level in two places at once, so that handler code can take it directly as a byte or as a word index.

The block compares the highest pending level with the processor priority it receives. When that level is strictly higher, it drives a request toward the CPU, carrying the encoded level. The CPU takes the request with a one-cycle acknowledge. The handler then clears the serviced flag by writing the register again, and the next pending level comes forward at once.

The register is readable and writable in the same clock cycle as a bus access. The request output follows from registered state, so a qualifying write shows up at the very next instruction boundary.

Top module: `pirq_reg`

## Requirements
- R1: After reset, the read data is 0x0000 and no request is driven.
- R2: A write with byte enable bit 1 set loads bits 15:8 of the write data into the request flags. The read data then shows them in bits 15:8.
- R3: A write with only byte enable bit 0 set leaves the whole register, and the request output, unchanged.
- R4: The low byte reads as the highest pending level L times 0x22. That places L in bits 3:1 and again in bits 7:5, with bits 0 and 4 zero.
- R5: When several flags are set, the code and the request level give the highest of them. For example, levels 1 and 3 read as 0x66.
- R6: The level-0 flag (bit 8) alone gives code 0x00 and no request.
- R7: A write that makes the highest level L greater than the CPU priority drives the request with level L. The request is present in the first cycle after that write's clock edge.
- R8: A level at or below the CPU priority stays pending without a request. The request appears once the priority drops below that level.
- R9: A word write of zero cancels every pending level and the request.
- R10: An acknowledge while the request is high withdraws the request from the next cycle on. It stays withdrawn until the register is written or the CPU priority input changes value.
- R11: Clearing the flag of the level being serviced moves the code and the request level to the next highest pending level in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Register access this cycle |
| busWe | input | 1 | Access is a write |
| busBe | input | 2 | Byte enables: bit 1 upper byte, bit 0 lower byte |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data: request flags and level code |
| cpuPri | input | 3 | Current processor priority |
| intAck | input | 1 | CPU takes the request |
| intReq | output | 1 | Interrupt request valid |
| intLevel | output | 3 | Level of the request, 1 to 7 |

## Verification
Single-level writes at every level check the doubled code field one level at a time. Mixed patterns such as levels 1+2, 1+3 and all levels show whether the encoder picks the highest level or just some set bit. A lone level-0 write and a lower-byte-only write each must leave the request output quiet, which separates a stored flag from a live one. Priority sweeps above, equal to and below the pending level pin down the strict comparison. The acknowledge sequence, followed by a priority change, shows that a taken request is not presented twice.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int LVL_W  = 3;
  localparam int N_LVL  = 1 << LVL_W;
  localparam int DATA_W = 2 * N_LVL;

  typedef struct packed {
    logic loadReq;
    logic loByteWr;
  } pirq_strb_t;
endpackage

// File: rtl/pirq_dp.sv
module pirq_dp
  import pirq_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  pirq_strb_t          strb,
  input  logic [N_LVL-1:0]    wrByte,
  input  logic [LVL_W-1:0]    cpuPri,
  output logic [DATA_W-1:0]   rdData,
  output logic [LVL_W-1:0]    topLevel,
  output logic                above
);
  logic [N_LVL-1:0] reqBits;

  always_ff @(posedge clk) begin
    if (!rstN)             reqBits <= '0;
    else if (strb.loadReq) reqBits <= wrByte;
  end

  // highest set flag among levels 1..N_LVL-1; level 0 never counts
  always_comb begin
    topLevel = '0;
    for (int i = 1; i < N_LVL; i++)
      if (reqBits[i]) topLevel = LVL_W'(i);
  end

  assign above  = topLevel > cpuPri;
  assign rdData = {reqBits, topLevel, 1'b0, topLevel, 1'b0};

  a_r4_code_form: assert property (@(posedge clk) disable iff (!rstN)
    rdData[0] == 1'b0 && rdData[4] == 1'b0 && rdData[3:1] == rdData[7:5]);
  a_r2_hi_load: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadReq |=> rdData[DATA_W-1:N_LVL] == $past(wrByte));
  a_r3_lo_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loByteWr && !strb.loadReq) |=> $stable(rdData));
endmodule

// File: rtl/pirq_ctrl.sv
module pirq_ctrl
  import pirq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             busSel,
  input  logic             busWe,
  input  logic [1:0]       busBe,
  input  logic [LVL_W-1:0] cpuPri,
  input  logic             intAck,
  input  logic             above,
  input  logic [LVL_W-1:0] topLevel,
  output pirq_strb_t       strb,
  output logic             intReq,
  output logic [LVL_W-1:0] intLevel
);
  logic             served;
  logic [LVL_W-1:0] prevPri;
  logic             priChg;

  assign strb.loadReq  = busSel && busWe && busBe[1];
  assign strb.loByteWr = busSel && busWe && busBe[0];
  assign priChg        = cpuPri != prevPri;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      served  <= 1'b0;
      prevPri <= '0;
    end else begin
      prevPri <= cpuPri;
      if (intAck && intReq)              served <= 1'b1;
      else if (strb.loadReq || priChg)   served <= 1'b0;
    end
  end

  assign intReq   = above && !served;
  assign intLevel = topLevel;

  a_r10_hold_after_ack: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && intReq) |=> !intReq);
  a_r8_strictly_above: assert property (@(posedge clk) disable iff (!rstN)
    intReq |-> intLevel > cpuPri);
  a_r6_no_level_zero: assert property (@(posedge clk) disable iff (!rstN)
    intReq |-> intLevel != '0);
endmodule

// File: rtl/pirq_reg.sv
module pirq_reg
  import pirq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [1:0]        busBe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [LVL_W-1:0]  cpuPri,
  input  logic              intAck,
  output logic              intReq,
  output logic [LVL_W-1:0]  intLevel
);
  pirq_strb_t       strb;
  logic [LVL_W-1:0] topLevel;
  logic             above;
  logic [N_LVL-1:0] loIgnored;

  assign loIgnored = busWdata[N_LVL-1:0];

  pirq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe), .busBe(busBe),
    .cpuPri(cpuPri), .intAck(intAck), .above(above), .topLevel(topLevel),
    .strb(strb), .intReq(intReq), .intLevel(intLevel)
  );

  pirq_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrByte(busWdata[DATA_W-1:N_LVL]),
    .cpuPri(cpuPri), .rdData(busRdata), .topLevel(topLevel), .above(above)
  );

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rstN |=> (busRdata == '0 && !intReq));
endmodule

// File: tb/sim_pirq_reg.sv
`timescale 1ns/1ps
module sim_pirq_reg;
  typedef struct {
    string       tag;
    logic [15:0] expRd;
    bit          expReq;
    logic [2:0]  expLvl;
  } item_t;

  logic clk = 0, rstN = 0, busSel = 0, busWe = 0, intAck = 0;
  logic [1:0] busBe = 0;
  logic [15:0] busWdata = 0, busRdata;
  logic [2:0] cpuPri = 0, intLevel;
  logic intReq;

  item_t q[$];
  int total = 0, bad = 0;
  bit done = 0;
  logic [7:0] mdlBits = 0;
  logic [2:0] mdlPri = 0;
  bit mdlServed = 0;

  always #10 clk = ~clk;

  pirq_reg u0 (.clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe),
    .busBe(busBe), .busWdata(busWdata), .busRdata(busRdata), .cpuPri(cpuPri),
    .intAck(intAck), .intReq(intReq), .intLevel(intLevel));

  function automatic logic [2:0] top(input logic [7:0] b);
    logic [2:0] t = 0;
    for (int i = 1; i < 8; i++) if (b[i]) t = 3'(i);
    return t;
  endfunction

  task automatic check(input string tag);
    item_t it;
    logic [2:0] t = top(mdlBits);
    it.tag = tag;
    it.expRd = {mdlBits, t, 1'b0, t, 1'b0};
    it.expReq = (t > mdlPri) && !mdlServed;
    it.expLvl = t;
    q.push_back(it);
    wait (q.size() == 0);
  endtask

  task automatic wr(input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    busSel = 1; busWe = 1; busBe = be; busWdata = d;
    @(posedge clk); #1;
    busSel = 0; busWe = 0; busBe = 0;
    if (be[1]) begin mdlBits = d[15:8]; mdlServed = 0; end
  endtask

  task automatic setPri(input logic [2:0] p);
    @(negedge clk);
    cpuPri = p;
    @(posedge clk); #1;
    if (p != mdlPri) mdlServed = 0;
    mdlPri = p;
  endtask

  task automatic ack();
    bit wasReq;
    @(negedge clk);
    wasReq = intReq;
    intAck = 1;
    @(posedge clk); #1;
    intAck = 0;
    if (wasReq) mdlServed = 1;
  endtask

  // monitor: pops expectations and compares against outputs
  initial forever begin
    item_t it;
    wait (q.size() != 0);
    #1;
    it = q.pop_front();
    total++;
    if (busRdata !== it.expRd || intReq !== it.expReq ||
        (it.expReq && intLevel !== it.expLvl)) begin
      bad++;
      $display("FAIL %s: rd=%h req=%b lvl=%0d expected rd=%h req=%b lvl=%0d",
        it.tag, busRdata, intReq, intLevel, it.expRd, it.expReq, it.expLvl);
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1; rstN = 1;
    check("R1 reset state");
    wr(2'b10, 16'h0600); check("R2 upper byte load, levels 1+2");
    wr(2'b01, 16'h00FF); check("R3 low byte write ignored");
    wr(2'b11, 16'h0100); check("R6 level 0 alone");
    setPri(3);
    wr(2'b10, 16'h1000); check("R7 level 4 above pri 3 next cycle");
    wr(2'b10, 16'h0400); check("R8 level 2 held at pri 3");
    setPri(2);           check("R8 level 2 held at equal pri 2");
    setPri(1);           check("R8 level 2 taken at pri 1");
    setPri(0);
    wr(2'b10, 16'h0A00); check("R5 levels 1+3 report 3");
    wr(2'b10, 16'hFE00); check("R11 all levels report 7");
    wr(2'b10, 16'h7E00); check("R11 cleared 7 gives 6");
    wr(2'b10, 16'h3E00); check("R11 cleared 6 gives 5");
    ack();               check("R10 request withdrawn after ack");
    @(posedge clk); #1;  check("R10 still withdrawn while idle");
    setPri(2);           check("R10 request back after pri change");
    ack();               check("R10 withdrawn again");
    wr(2'b10, 16'h3E00); check("R10 request back after write");
    wr(2'b11, 16'h0000); check("R9 zero write cancels all");
    for (int l = 1; l < 8; l++) begin
      wr(2'b10, 16'(1 << (8 + l)));
      check($sformatf("R4 code for single level %0d", l));
    end
    wr(2'b11, 16'h0000);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule